// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block lets a host read and write a bank of byte-wide configuration registers through three signals: an active-low select, a serial clock, and one data line that both sides share. Each framed command starts with a direction bit. A 7-bit register address follows, then one or more data bytes. All fields are sent most significant bit first. The three pins are brought into a faster system clock through two-flop synchronizers, and the block acts on serial clock edges that it detects in that domain. The system clock must run at least four times faster than the serial clock.

A write may carry a single byte or a burst. In a burst, each further complete byte goes to the next address, and the address wraps from the last implemented register back to zero. A byte cut short by the select rising is thrown away. A read returns one byte, and only when the read-enable bit in register 0x00 is set. Otherwise the data line is never driven. The pin is modelled as a data-out, an output-enable and a data-in. Every register update also shows up as a one-cycle strobe with its address and data.

Top module: `twp_reg_port`

## Requirements
- R1: A frame is a direction bit (1 = write, 0 = read), then a 7-bit address and 8-bit data, all sent MSB first and sampled on rising serial clock edges.
- R2: A write frame updates the addressed register once its 16th rising edge is seen. That update also raises `wr_stb` for exactly one system cycle, with the matching `wr_addr` and `wr_data`.
- R3: While select stays low after the first data byte, each further complete byte is written to the address one above the previous one.
- R4: During a burst, the address after 0x6E is 0x00.
- R5: If select rises before a byte is complete, that partial byte writes nothing, and the bytes completed earlier in the frame are kept.
- R6: When the read-enable bit (bit 0 of register 0x00) is 1, a read frame raises `sdo_oe` after the 8th falling edge. It then presents D7 first, with each later falling edge moving to the next lower bit.
- R7: When the read-enable bit is 0, `sdo_oe` stays 0 for the whole read frame.
- R8: `sdo_oe` is 0 whenever select is high, and throughout write frames.
- R9: While `rst_n` is low, every register returns to 0x00, and `sdo_oe` and `wr_stb` are 0.
- R10: A write to an address above 0x6E changes nothing and raises no strobe. A read from such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores register defaults |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Data line as seen at the pin (input path) |
| sdo | output | 1 | Data driven toward the pin during read output |
| sdo_oe | output | 1 | Output enable for the data pin |
| wr_stb | output | 1 | One-cycle pulse per register update |
| wr_addr | output | 7 | Address of the register being updated |
| wr_data | output | 8 | Value written with the strobe |

## Verification
The bench goes after several corner cases:
- A burst that starts at 0x6D must land its third byte at 0x00. A design that forgot the wrap would write an unimplemented address, and the read-enable bit would keep its old value.
- A frame cut off five bits into its second byte must leave the next register untouched. A design that flushed partial bytes would corrupt it.
- Reads with the enable bit cleared must never assert the output enable, and neither must the header half of an enabled read. A design that drove early, or ignored the gate, would contend on the shared line.
- Addresses above 0x6E must stay silent on both writes and reads.
- After a reset pulse, reads must return zeros.

// File: rtl/twp_pkg.sv
package twp_pkg;
  localparam int unsigned TWP_DW = 8;
  localparam int unsigned TWP_AW = TWP_DW - 1;
  localparam logic [TWP_AW-1:0] TWP_LAST = 7'h6E;
endpackage

// File: rtl/twp_sync.sv
module twp_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync,
  output logic [W-1:0] d_prev
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, h_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
        h_q  <= RST_VAL[g];
      end else begin
        s1_q <= d_async[g];
        s2_q <= s1_q;
        h_q  <= s2_q;
      end
    end
    assign d_sync[g] = s2_q;
    assign d_prev[g] = h_q;
  end
endmodule

// File: rtl/twp_regbank.sv
module twp_regbank #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] LAST = 7'h6E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          read_en
);
  localparam int unsigned NREG = int'(LAST) + 1;

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (hit) regs_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr <= LAST) rdata = regs_q[raddr];
  end

  assign read_en = regs_q[0][0];

  // R6
  rden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == '0) |=> (read_en == $past(wdata[0])));
endmodule

// File: rtl/twp_frame.sv
module twp_frame #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] LAST = 7'h6E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_hi,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          sdi_s,
  input  logic          read_en,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] CMAX = CW'(DW - 1);

  logic          hdr_q, hdr_n;
  logic          dir_q, dir_n;
  logic          tried_q, tried_n;
  logic          oe_q, oe_n;
  logic [CW-1:0] bcnt_q, bcnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [DW-1:0] osh_q, osh_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          stb_q, stb_n;
  logic [AW-1:0] saddr_q, saddr_n;
  logic [DW-1:0] sdata_q, sdata_n;
  logic [AW-1:0] addr_inc;

  assign addr_inc = (addr_q == LAST) ? '0 : addr_q + 1'b1;

  always_comb begin
    hdr_n   = hdr_q;
    dir_n   = dir_q;
    tried_n = tried_q;
    oe_n    = oe_q;
    bcnt_n  = bcnt_q;
    sh_n    = sh_q;
    osh_n   = osh_q;
    addr_n  = addr_q;
    stb_n   = 1'b0;
    saddr_n = saddr_q;
    sdata_n = sdata_q;
    if (cs_hi) begin
      hdr_n   = 1'b0;
      dir_n   = 1'b0;
      tried_n = 1'b0;
      oe_n    = 1'b0;
      bcnt_n  = '0;
    end else begin
      if (sck_rise) begin
        sh_n   = {sh_q[DW-2:0], sdi_s};
        bcnt_n = bcnt_q + 1'b1;
        if (bcnt_q == CMAX) begin
          if (!hdr_q) begin
            hdr_n  = 1'b1;
            dir_n  = sh_n[DW-1];
            addr_n = sh_n[AW-1:0];
          end else if (dir_q) begin
            if (addr_q <= LAST) begin
              stb_n   = 1'b1;
              saddr_n = addr_q;
              sdata_n = sh_n;
            end
            addr_n = addr_inc;
          end
        end
      end
      if (sck_fall) begin
        if (hdr_q && !dir_q && !tried_q) begin
          tried_n = 1'b1;
          if (read_en) begin
            oe_n  = 1'b1;
            osh_n = rd_data;
          end
        end else if (oe_q) begin
          osh_n = {osh_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q   <= 1'b0;
      dir_q   <= 1'b0;
      tried_q <= 1'b0;
      oe_q    <= 1'b0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      osh_q   <= '0;
      addr_q  <= '0;
      stb_q   <= 1'b0;
      saddr_q <= '0;
      sdata_q <= '0;
    end else begin
      hdr_q   <= hdr_n;
      dir_q   <= dir_n;
      tried_q <= tried_n;
      oe_q    <= oe_n;
      bcnt_q  <= bcnt_n;
      sh_q    <= sh_n;
      osh_q   <= osh_n;
      addr_q  <= addr_n;
      stb_q   <= stb_n;
      saddr_q <= saddr_n;
      sdata_q <= sdata_n;
    end
  end

  assign rd_addr = addr_q;
  assign sdo     = oe_q & osh_q[DW-1];
  assign sdo_oe  = oe_q;
  assign wr_stb  = stb_q;
  assign wr_addr = saddr_q;
  assign wr_data = sdata_q;

  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && $past(cs_hi)) |-> !oe_q);
  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> (read_en && !dir_q && hdr_q));
  // R2
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R10
  stb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (saddr_q <= LAST));
endmodule

// File: rtl/twp_reg_port.sv
module twp_reg_port
  import twp_pkg::*;
#(
  parameter int unsigned DW = TWP_DW,
  parameter logic [DW-2:0] LAST = TWP_LAST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          wr_stb,
  output logic [DW-2:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int unsigned AW = DW - 1;

  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  logic [2:0] pin_s, pin_p;
  twp_sync #(.W(3), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst_n(rs2_q), .d_async({cs_n, sclk, sdi}),
    .d_sync(pin_s), .d_prev(pin_p)
  );

  logic cs_hi, sck_rise, sck_fall;
  assign cs_hi    = pin_s[2];
  assign sck_rise = pin_s[1] & ~pin_p[1];
  assign sck_fall = ~pin_s[1] & pin_p[1];

  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          read_en;

  twp_frame #(.AW(AW), .DW(DW), .LAST(LAST)) frame_i (
    .clk(clk), .rst_n(rs2_q), .cs_hi(cs_hi), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .sdi_s(pin_s[0]), .read_en(read_en),
    .rd_data(rd_data), .rd_addr(rd_addr), .sdo(sdo), .sdo_oe(sdo_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  twp_regbank #(.AW(AW), .DW(DW), .LAST(LAST)) bank_i (
    .clk(clk), .rst_n(rs2_q), .we(wr_stb), .waddr(wr_addr),
    .wdata(wr_data), .raddr(rd_addr), .rdata(rd_data), .read_en(read_en)
  );
endmodule

// File: tb/twp_reg_port_tb_top.sv
module twp_reg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  always #10 clk = ~clk;

  twp_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  int n_chk = 0, n_bad = 0, n_stb = 0;
  logic [6:0] last_a;
  logic [7:0] last_d;
  bit done = 0;

  always @(negedge clk) if (wr_stb) begin
    n_stb++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bits sent MSB first: bit i is bits[127-i]
  task automatic xfer(input logic [127:0] bits, input int nbits,
                      output logic [127:0] rx, output logic [127:0] oe);
    rx = '0; oe = '0;
    cs_n = 1'b0;
    cyc(5);
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[127-i];
      cyc(5);
      rx[127-i] = sdo;
      oe[127-i] = sdo_oe;
      sclk = 1'b1;
      cyc(5);
      sclk = 1'b0;
    end
    cyc(10);
    cs_n = 1'b1;
    cyc(10);
  endtask

  task automatic wr_burst(input logic [6:0] a, input logic [31:0] d, input int nbits_data);
    logic [127:0] rx, oe;
    xfer({1'b1, a, d, 88'd0}, 8 + nbits_data, rx, oe);
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] v,
                     output bit oe_hdr, output bit oe_all);
    logic [127:0] rx, oe;
    xfer({1'b0, a, 120'd0}, 16, rx, oe);
    v = rx[119:112];
    oe_hdr = |oe[127:120];
    oe_all = &oe[119:112];
  endtask

  localparam logic [22:0] VEC [6] = '{
    {7'h00, 8'h01, 8'h01},
    {7'h10, 8'hA5, 8'hA5},
    {7'h6E, 8'h3C, 8'h3C},
    {7'h01, 8'hFF, 8'hFF},
    {7'h70, 8'h55, 8'h00},
    {7'h7F, 8'h12, 8'h00}
  };

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit oh, oa;
    int s0;
    cyc(3);
    // R9 reset state at the ports
    chk(sdo_oe == 1'b0, "R9 oe in reset", sdo_oe, 0);
    chk(wr_stb == 1'b0, "R9 strobe in reset", wr_stb, 0);
    rst_n = 1'b1;
    cyc(5);

    // R7 read enable is 0 after reset: line never driven
    rd1(7'h00, v, oh, oa);
    chk(!oh && !oa, "R7 no drive with READ=0", {oh, oa}, 0);

    // vector table: write then read back (R1, R2, R6, R10)
    foreach (VEC[k]) begin
      logic [6:0] a;
      logic [7:0] d, e;
      {a, d, e} = VEC[k];
      s0 = n_stb;
      wr_burst(a, {d, 24'd0}, 8);
      if (a <= 7'h6E) begin
        chk(n_stb == s0 + 1 && last_a == a && last_d == d, "R2 strobe addr/data",
            {last_a, last_d}, {a, d});
      end else begin
        chk(n_stb == s0, "R10 no strobe above 0x6E", n_stb - s0, 0);
      end
      rd1(a, v, oh, oa);
      chk(v == e && !oh && oa, "R1 R6 readback", {oh, oa, v}, {2'b01, e});
    end

    // R3 R4 burst with wrap from 0x6E to 0x00
    s0 = n_stb;
    wr_burst(7'h6D, {8'h11, 8'h22, 8'h33, 8'h00}, 24);
    chk(n_stb == s0 + 3, "R3 three strobes", n_stb - s0, 3);
    rd1(7'h6D, v, oh, oa);
    chk(v == 8'h11, "R3 burst byte 0", v, 8'h11);
    rd1(7'h6E, v, oh, oa);
    chk(v == 8'h22, "R3 burst byte 1", v, 8'h22);
    rd1(7'h00, v, oh, oa);
    chk(v == 8'h33, "R4 wrap to 0x00", v, 8'h33);

    // R5 partial trailing byte discarded
    s0 = n_stb;
    wr_burst(7'h20, {8'h44, 8'h99, 16'd0}, 13);
    chk(n_stb == s0 + 1, "R5 single strobe", n_stb - s0, 1);
    rd1(7'h20, v, oh, oa);
    chk(v == 8'h44, "R5 completed byte kept", v, 8'h44);
    rd1(7'h21, v, oh, oa);
    chk(v == 8'h00, "R5 partial byte dropped", v, 0);

    // R8 line released once select is high
    chk(sdo_oe == 1'b0, "R8 oe low with select high", sdo_oe, 0);

    // R7 clear read enable, then a read never drives
    wr_burst(7'h00, {8'h00, 24'd0}, 8);
    rd1(7'h10, v, oh, oa);
    chk(!oh && !oa, "R7 gated read", {oh, oa}, 0);

    // R9 reset mid-run restores defaults
    rst_n = 1'b0;
    cyc(4);
    chk(sdo_oe == 1'b0 && wr_stb == 1'b0, "R9 outputs in reset", {sdo_oe, wr_stb}, 0);
    rst_n = 1'b1;
    cyc(5);
    wr_burst(7'h00, {8'h01, 24'd0}, 8);
    rd1(7'h10, v, oh, oa);
    chk(v == 8'h00 && oa, "R9 register back to 0", v, 0);
    rd1(7'h01, v, oh, oa);
    chk(v == 8'h00, "R9 register 0x01 back to 0", v, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule